// File: doc/BRIEF.md
# Six-Pin Bidirectional GPIO Port Controller

This block drives six general-purpose pins through a small register interface. Each pin has a direction bit and an output latch, and every pin except one has a weak pull-up enable. A single global bit can hold all software pull-ups off. The block does not model the pads. It hands output-enable, output-data and pull-up-enable signals to the pad wrappers. It also takes the raw pad levels back, passes them through a synchronizer and presents them to software.

Pin 3 is input only. Its driver is never enabled and its direction bit always reads 1. A chip-level input, `resetPinEn`, can hand this pin to an external reset function. While that input is high, pin 3 reads 0 and has a pull-up that software cannot touch. Per-pin analog-select inputs mask port reads to zero. They leave the driver under the control of the direction register.

Each register access is a full write, a set of one bit or a clear of one bit. A set or clear on the port register is read-modify-write. The block takes the synchronized and masked pin view, changes one bit and loads the whole result into the output latch.

Top module: `pinbank6`

## Requirements
- R1: The register map is: address 0 = port, 1 = direction, 2 = pull-up enables, 3 = config, where config bit 0 is the global pull-up disable. Only bits 5:0 of any register are implemented, and bits 7:6 always read 0.
- R2: A direction bit of 1 makes the pin an input (`padOe` low). A direction bit of 0 sets `padOe` high, and `padOut` always carries the output latch.
- R3: Pin 3 is input only. `padOe[3]` is always 0, and direction bit 3 reads 1 whatever value was written to it.
- R4: A port read returns the pad levels after a two-flop synchronizer, so a pad change shows up in reads two clock edges later. A full port write loads the output latch and has no effect on the read value.
- R5: `busOp` encodes 0 = write, 1 = set bit `busBit`, 2 = clear bit `busBit`. A set or clear on the port loads the latch with the current port read value with that one bit changed.
- R6: A pin whose `analogSel` bit is high reads 0 in the port register. The direction register still controls its `padOe`.
- R7: While `resetPinEn` is high, port bit 3 reads 0 and `padPullEn[3]` is 1. While it is low, `padPullEn[3]` is 0.
- R8: For every pin other than 3, `padPullEn` = pull-up enable bit AND direction bit AND NOT global disable, so the pull-up is off on output pins.
- R9: After reset, the direction register is all inputs (0x3F), the pull-up enables are all set (read 0x37), and the global disable is 1, which turns all software pull-ups off.
- R10: A set or clear on the direction, pull-up or config register changes only the selected bit of that register.
- R11: An access with `busOp` = 3 changes no register.
- R12: Pull-up enable bit 3 cannot be set by software and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Access strobe |
| busWrite | input | 1 | Access is a write-type operation |
| busAddr | input | 2 | Register address |
| busOp | input | 2 | Write, set bit, clear bit or reserved |
| busBit | input | 3 | Bit index for set and clear |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register (combinational) |
| padIn | input | 6 | Raw pad levels |
| analogSel | input | 6 | Per-pin analog select |
| resetPinEn | input | 1 | Pin 3 claimed by the reset function |
| padOe | output | 6 | Output driver enable per pin |
| padOut | output | 6 | Output data per pin |
| padPullEn | output | 6 | Weak pull-up enable per pin |

## Verification
All 64 pad patterns are read back under four analog masks with the reset function both on and off. This separates the masking by analog select from the masking of pin 3 and from the synchronizer delay. All 64 direction values are written and checked for the forced pin-3 bit. The full 64-by-64 cross of direction and pull-up values is applied under both global-disable states, which tells the output-pin suppression apart from the global gating. Set and clear on the port run over every bit under mixed pad, analog and reset-pin conditions. This exposes any design that modifies the latch contents instead of the sampled pin view.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    ADDR_PORT = 2'd0,
    ADDR_DIR  = 2'd1,
    ADDR_PULL = 2'd2,
    ADDR_CFG  = 2'd3
  } regAddr_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } busOp_e;

  typedef struct packed {
    logic             ldPort;
    logic             ldDir;
    logic             ldPull;
    logic             ldCfg;
    logic [REG_W-1:0] value;
  } strobes_t;
endpackage

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int BIT_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [1:0]           busAddr,
  input  logic [1:0]           busOp,
  input  logic [BIT_IDX_W-1:0] busBit,
  input  logic [REG_W-1:0]     busWdata,
  input  logic [REG_W-1:0]     curValue,
  output strobes_t             strobes
);
  logic [REG_W-1:0] bitMask;
  logic [REG_W-1:0] merged;
  logic             doAccess;
  regAddr_e         addrE;
  busOp_e           opE;

  assign addrE    = regAddr_e'(busAddr);
  assign opE      = busOp_e'(busOp);
  assign bitMask  = REG_W'(1) << busBit;
  assign doAccess = busValid && busWrite && (opE != OP_NONE);

  // Set/clear take the current read view of the addressed register.
  always_comb begin
    unique case (opE)
      OP_SET:   merged = curValue | bitMask;
      OP_CLEAR: merged = curValue & ~bitMask;
      default:  merged = busWdata;
    endcase
  end

  always_comb begin
    strobes        = '0;
    strobes.value  = merged;
    strobes.ldPort = doAccess && (addrE == ADDR_PORT);
    strobes.ldDir  = doAccess && (addrE == ADDR_DIR);
    strobes.ldPull = doAccess && (addrE == ADDR_PULL);
    strobes.ldCfg  = doAccess && (addrE == ADDR_CFG);
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.ldPort, strobes.ldDir, strobes.ldPull, strobes.ldCfg})); // R1
endmodule

// File: rtl/pinbank_dp.sv
module pinbank_dp
  import pinbank_pkg::*;
#(
  parameter int WIDTH          = 6,
  parameter int INPUT_ONLY_PIN = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [1:0]       rdAddr,
  input  logic [WIDTH-1:0] padIn,
  input  logic [WIDTH-1:0] analogSel,
  input  logic             resetPinEn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullEn,
  output logic [REG_W-1:0] rdValue
);
  localparam logic [WIDTH-1:0] ONLY_MASK = WIDTH'(1) << INPUT_ONLY_PIN;
  localparam logic [WIDTH-1:0] ALL_ONES  = '1;

  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] pullQ;
  logic             gdisQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] portView;
  logic [WIDTH-1:0] rstPinMask;

  // Output latch: no reset, contents undefined until first write.
  always_ff @(posedge clk) begin
    if (strobes.ldPort) latchQ <= strobes.value[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= ALL_ONES;
      pullQ <= ALL_ONES & ~ONLY_MASK;
      gdisQ <= 1'b1;
    end else begin
      if (strobes.ldDir)  dirQ  <= strobes.value[WIDTH-1:0] | ONLY_MASK;
      if (strobes.ldPull) pullQ <= strobes.value[WIDTH-1:0] & ~ONLY_MASK;
      if (strobes.ldCfg)  gdisQ <= strobes.value[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign rstPinMask = resetPinEn ? ONLY_MASK : '0;
  assign portView   = syncQ[SYNC_STAGES-1] & ~analogSel & ~rstPinMask;

  always_comb begin
    unique case (regAddr_e'(rdAddr))
      ADDR_PORT: rdValue = REG_W'(portView);
      ADDR_DIR:  rdValue = REG_W'(dirQ);
      ADDR_PULL: rdValue = REG_W'(pullQ);
      default:   rdValue = REG_W'(gdisQ);
    endcase
  end

  assign padOut = latchQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i == INPUT_ONLY_PIN) begin : g_inOnly
      assign padOe[i]     = 1'b0;
      assign padPullEn[i] = resetPinEn;
    end else begin : g_bidir
      assign padOe[i]     = ~dirQ[i];
      assign padPullEn[i] = pullQ[i] & dirQ[i] & ~gdisQ;

      AST_NO_PULL_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
        padOe[i] |-> !padPullEn[i]); // R8
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdValue >> WIDTH) == '0); // R1

  AST_IN_ONLY_DIR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr_e'(rdAddr) == ADDR_DIR) |-> rdValue[INPUT_ONLY_PIN]); // R3

  AST_ANALOG_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr_e'(rdAddr) == ADDR_PORT) |-> ((rdValue[WIDTH-1:0] & analogSel) == '0)); // R6

  AST_RSTPIN_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (resetPinEn && regAddr_e'(rdAddr) == ADDR_PORT) |-> !rdValue[INPUT_ONLY_PIN]); // R7

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ldPort |=> (padOut == $past(strobes.value[WIDTH-1:0]))); // R4

  AST_GDIS_GATES: assert property (@(posedge clk) disable iff (!rstN)
    gdisQ |-> ((padPullEn & ~ONLY_MASK) == '0)); // R8
endmodule

// File: rtl/pinbank6.sv
module pinbank6
  import pinbank_pkg::*;
#(
  parameter int WIDTH          = 6,
  parameter int INPUT_ONLY_PIN = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int BIT_IDX_W      = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [1:0]           busAddr,
  input  logic [1:0]           busOp,
  input  logic [BIT_IDX_W-1:0] busBit,
  input  logic [7:0]           busWdata,
  output logic [7:0]           busRdata,
  input  logic [WIDTH-1:0]     padIn,
  input  logic [WIDTH-1:0]     analogSel,
  input  logic                 resetPinEn,
  output logic [WIDTH-1:0]     padOe,
  output logic [WIDTH-1:0]     padOut,
  output logic [WIDTH-1:0]     padPullEn
);
  strobes_t strobes;

  pinbank_ctrl #(.BIT_IDX_W(BIT_IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busOp    (busOp),
    .busBit   (busBit),
    .busWdata (busWdata),
    .curValue (busRdata),
    .strobes  (strobes)
  );

  pinbank_dp #(
    .WIDTH          (WIDTH),
    .INPUT_ONLY_PIN (INPUT_ONLY_PIN),
    .SYNC_STAGES    (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rdAddr     (busAddr),
    .padIn      (padIn),
    .analogSel  (analogSel),
    .resetPinEn (resetPinEn),
    .padOe      (padOe),
    .padOut     (padOut),
    .padPullEn  (padPullEn),
    .rdValue    (busRdata)
  );

  AST_RESERVED_OP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busOp == 2'd3) |=> ($stable(padOut) && $stable(padOe))); // R11

  AST_IN_ONLY_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == 2'd1) |=> !padOe[INPUT_ONLY_PIN]); // R3
endmodule

// File: tb/pinbank6_tb.sv
`timescale 1ns/1ps
module pinbank6_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busValid = 1'b0, busWrite = 1'b0;
  logic [1:0] busAddr = 2'd0, busOp = 2'd0;
  logic [2:0] busBit = 3'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic [5:0] padIn = 6'd0, analogSel = 6'd0;
  logic       resetPinEn = 1'b0;
  logic [5:0] padOe, padOut, padPullEn;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pinbank6 u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busOp(busOp), .busBit(busBit), .busWdata(busWdata),
    .busRdata(busRdata), .padIn(padIn), .analogSel(analogSel),
    .resetPinEn(resetPinEn), .padOe(padOe), .padOut(padOut), .padPullEn(padPullEn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Called aligned to a negedge; the update happens at the next posedge.
  task automatic acc(input logic [1:0] a, input logic [1:0] op,
                     input logic [2:0] b, input logic [7:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busOp = op; busBit = b; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  function automatic logic [5:0] expPull(input logic [5:0] dir, input logic [5:0] wpu,
                                         input logic gdis, input logic rpe);
    logic [5:0] p;
    p = wpu & dir & {6{~gdis}};
    p[3] = rpe;
    return p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [5:0] view, m;
    logic [5:0] pats [5];
    logic [5:0] amasks [4];
    pats[0] = 6'h00; pats[1] = 6'h3F; pats[2] = 6'h2A; pats[3] = 6'h15; pats[4] = 6'h33;
    amasks[0] = 6'h00; amasks[1] = 6'h15; amasks[2] = 6'h2A; amasks[3] = 6'h3F;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    rd(2'd1, v); chk("R9 dir reset", v, 8'h3F);
    rd(2'd2, v); chk("R9 R12 pull reset", v, 8'h37);
    rd(2'd3, v); chk("R9 cfg reset", v, 8'h01);
    chk("R2 oe reset", {2'b0, padOe}, 8'h00);
    chk("R9 pulls off at reset", {2'b0, padPullEn}, 8'h00);

    // Direction sweep
    for (int d = 0; d < 64; d++) begin
      acc(2'd1, 2'd0, 3'd0, {2'b11, 6'(d)});
      rd(2'd1, v); chk("R3 R1 dir read", v, {2'b00, 6'(d) | 6'h08});
      chk("R2 R3 oe", {2'b0, padOe}, {2'b00, ~(6'(d) | 6'h08)});
    end

    // Synchronizer latency and write-not-read-back
    acc(2'd1, 2'd0, 3'd0, 8'h00);
    padIn = 6'h00;
    repeat (2) @(negedge clk);
    padIn = 6'h37;
    @(negedge clk);
    rd(2'd0, v); chk("R4 one edge still old", v, 8'h00);
    @(negedge clk);
    rd(2'd0, v); chk("R4 two edges new", v, 8'h37);
    padIn = 6'h15;
    repeat (2) @(negedge clk);
    acc(2'd0, 2'd0, 3'd0, 8'h2A);
    chk("R4 R2 latch out", {2'b0, padOut}, 8'h2A);
    rd(2'd0, v); chk("R4 read is pins", v, 8'h15);

    // Read masking sweep (analog select still leaves driver on)
    analogSel = 6'h3F;
    chk("R6 analog keeps driver", {2'b0, padOe}, 8'h37);
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < 4; a++) begin
        for (int p = 0; p < 64; p++) begin
          padIn = 6'(p); analogSel = amasks[a]; resetPinEn = r[0];
          repeat (2) @(negedge clk);
          rd(2'd0, v);
          chk("R4 R6 R7 port read", v,
              {2'b00, 6'(p) & ~amasks[a] & (r[0] ? 6'h37 : 6'h3F)});
        end
      end
    end
    analogSel = 6'h00; resetPinEn = 1'b0;

    // Pull-up cross sweep
    for (int g = 0; g < 2; g++) begin
      acc(2'd3, 2'd0, 3'd0, {7'd0, g[0]});
      for (int d = 0; d < 64; d++) begin
        acc(2'd1, 2'd0, 3'd0, 8'(d));
        for (int w = 0; w < 64; w++) begin
          acc(2'd2, 2'd0, 3'd0, 8'(w));
          resetPinEn = 1'b0; #1;
          chk("R8 R7 pull", {2'b0, padPullEn},
              {2'b0, expPull(6'(d) | 6'h08, 6'(w) & 6'h37, g[0], 1'b0)});
          resetPinEn = 1'b1; #1;
          chk("R8 R7 pull rpe", {2'b0, padPullEn},
              {2'b0, expPull(6'(d) | 6'h08, 6'(w) & 6'h37, g[0], 1'b1)});
        end
      end
    end
    resetPinEn = 1'b0;

    // Pull-up bit 3 not software controlled
    acc(2'd2, 2'd0, 3'd0, 8'hFF);
    rd(2'd2, v); chk("R12 pull write", v, 8'h37);
    acc(2'd2, 2'd1, 3'd3, 8'h00);
    rd(2'd2, v); chk("R12 pull set bit3", v, 8'h37);

    // Port read-modify-write
    acc(2'd1, 2'd0, 3'd0, 8'h00);
    for (int pi = 0; pi < 5; pi++) begin
      for (int a = 0; a < 2; a++) begin
        for (int r = 0; r < 2; r++) begin
          for (int b = 0; b < 6; b++) begin
            for (int op = 1; op <= 2; op++) begin
              padIn = pats[pi]; analogSel = a[0] ? 6'h05 : 6'h00; resetPinEn = r[0];
              acc(2'd0, 2'd0, 3'd0, {2'b00, ~pats[pi]});
              @(negedge clk);
              view = pats[pi] & ~analogSel & (r[0] ? 6'h37 : 6'h3F);
              m = 6'(1) << b;
              acc(2'd0, 2'(op), 3'(b), 8'h00);
              chk("R5 port rmw", {2'b0, padOut},
                  {2'b0, (op == 1) ? (view | m) : (view & ~m)});
            end
          end
        end
      end
    end
    analogSel = 6'h00; resetPinEn = 1'b0;

    // Set/clear on the other registers
    acc(2'd1, 2'd0, 3'd0, 8'h3F);
    acc(2'd1, 2'd2, 3'd1, 8'hFF);
    rd(2'd1, v); chk("R10 dir clear", v, 8'h3D);
    acc(2'd1, 2'd1, 3'd1, 8'h00);
    rd(2'd1, v); chk("R10 dir set", v, 8'h3F);
    acc(2'd2, 2'd2, 3'd5, 8'hFF);
    rd(2'd2, v); chk("R10 pull clear", v, 8'h17);
    acc(2'd3, 2'd2, 3'd0, 8'hFF);
    rd(2'd3, v); chk("R10 cfg clear", v, 8'h00);
    acc(2'd3, 2'd1, 3'd0, 8'h00);
    rd(2'd3, v); chk("R10 cfg set", v, 8'h01);

    // Reserved op changes nothing
    acc(2'd1, 2'd0, 3'd0, 8'h0C);
    acc(2'd0, 2'd0, 3'd0, 8'h19);
    for (int a = 0; a < 4; a++) acc(2'(a), 2'd3, 3'd2, 8'hA5);
    rd(2'd1, v); chk("R11 dir held", v, 8'h0C);
    rd(2'd2, v); chk("R11 pull held", v, 8'h17);
    rd(2'd3, v); chk("R11 cfg held", v, 8'h01);
    chk("R11 latch held", {2'b0, padOut}, 8'h19);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule